// File: doc/BRIEF.md
# Overlap current-error compensator

In a current-source inverter every switch is held on a little longer than the modulator asks, so that the DC-link inductor is never left without a path. During those overlap windows the bridge keeps delivering the old current vector whenever the commutation runs against the voltage gradient. Averaged over one carrier period, this gives a predictable error on each phase current. This block runs once per carrier period and removes that error before modulation. It takes the three sampled, filtered phase voltages, the DC-link current and the d/q inverter-current references.

The block sorts the three voltages. It gives the highest phase an error of −E, the lowest phase +E and the middle phase zero, where E = 2·fs·tov·idc. It then rotates that error into the d/q frame with the grid-angle sine and cosine and subtracts it from the references. The modulation sector plays no part. The product fs·tov arrives as one precomputed fixed-point constant. The corrected references leave the block saturated to the reference width, together with a one-cycle strobe.

Top module: `ovl_comp`

## Requirements
- R1: While reset is asserted and after its release, until the first accepted sample, `out_valid` is 0 and both corrected references are 0.
- R2: The error magnitude is E = floor(2·idc·k_fstov / 2^KFRAC), with idc unsigned and k_fstov unsigned in Q0.KFRAC. When idc or k_fstov is 0, the outputs equal the references.
- R3: The phase with the highest voltage receives −E, the phase with the lowest voltage receives +E, and the remaining phase receives 0.
- R4: Voltage ties are broken with fixed priority a over b over c. Among equal voltages, a counts as higher than b, and b counts as higher than c.
- R5: The phase errors (ea, eb) map to α = ea and β = (ea + 2·eb)/√3. They then map to Δd = α·cos + β·sin and Δq = −α·sin + β·cos. sin_th and cos_th are signed Q(TW−TFRAC).TFRAC, so 1.0 is 2^TFRAC. The result is exact to within 3 LSB.
- R6: id_cmd = id_ref − Δd and iq_cmd = iq_ref − Δq.
- R7: Each corrected reference saturates to the signed IW-bit range, [−2^(IW−1), 2^(IW−1)−1].
- R8: Each `in_valid` cycle produces exactly one `out_valid` pulse, three clock cycles later. Back-to-back samples are accepted on every cycle.
- R9: When `out_valid` is low, both outputs hold their last value. Input changes made while `in_valid` is low produce neither a strobe nor an output change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Carrier-period sample strobe |
| ua | input | VW | Phase a filtered voltage, signed |
| ub | input | VW | Phase b filtered voltage, signed |
| uc | input | VW | Phase c filtered voltage, signed |
| idc | input | IW | DC-link current, unsigned |
| k_fstov | input | KW | fs·tov product, unsigned Q0.KFRAC |
| sin_th | input | TW | Sine of grid angle, signed Q.TFRAC |
| cos_th | input | TW | Cosine of grid angle, signed Q.TFRAC |
| id_ref | input | IW | d-axis inverter-current reference, signed |
| iq_ref | input | IW | q-axis inverter-current reference, signed |
| out_valid | output | 1 | One-cycle strobe for corrected references |
| id_cmd | output | IW | Corrected d reference, signed |
| iq_cmd | output | IW | Corrected q reference, signed |

## Verification
The bench uses the default widths: 16-bit voltages, currents and fs·tov constant, KFRAC = 16, and 16-bit trigonometric inputs with 14 fraction bits. With these values a realistic fs·tov constant near 1966 gives an error of about 900 LSB. References near ±32767 then push both outputs into the saturation rails. A large k_fstov drives E to about 16383 without wrapping the intermediate products. At zero grid angle Δd equals ea and Δq is proportional to ea + 2·eb. The six orderings and the tie cases can therefore be read straight off the two outputs, while other angles exercise the rotation.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  // Voltage orderings, listed highest-middle-lowest
  typedef enum logic [2:0] {
    ORD_ABC, ORD_ACB, ORD_BAC, ORD_BCA, ORD_CAB, ORD_CBA
  } ovl_order_e;

  // 1/sqrt(3) in Q1.15
  localparam int INV_SQRT3_FRAC = 15;
  localparam int INV_SQRT3_Q    = 18919;
endpackage

// File: rtl/ovl_rank.sv
module ovl_rank
  import ovl_pkg::*;
#(
  parameter int VW    = 16,
  parameter int IW    = 16,
  parameter int KW    = 16,
  parameter int KFRAC = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            v_i,
  input  logic signed [VW-1:0]            ua,
  input  logic signed [VW-1:0]            ub,
  input  logic signed [VW-1:0]            uc,
  input  logic        [IW-1:0]            idc,
  input  logic        [KW-1:0]            k_fstov,
  output logic                            v_o,
  output logic signed [IW+KW+1-KFRAC:0]   ea_o,
  output logic signed [IW+KW+1-KFRAC:0]   eb_o
);
  localparam int MW = IW + KW + 1 - KFRAC;
  localparam int EW = MW + 1;
  localparam int PW = IW + KW + 1;

  function automatic logic [MW-1:0] err_mag(input logic [IW-1:0] i, input logic [KW-1:0] k);
    logic [PW-1:0] p;
    p = (PW'(i) * PW'(k)) << 1;
    return MW'(p >> KFRAC);
  endfunction

  logic              a_ge_b, a_ge_c, b_ge_c;
  ovl_order_e        order;
  logic [2:0]        hi_sel, lo_sel;
  logic [MW-1:0]     mag;
  logic signed [EW-1:0] pos_e, neg_e, ea_n, eb_n;

  assign a_ge_b = (ua >= ub);
  assign a_ge_c = (ua >= uc);
  assign b_ge_c = (ub >= uc);
  assign mag    = err_mag(idc, k_fstov);
  assign pos_e  = $signed({1'b0, mag});
  assign neg_e  = -pos_e;

  always_comb begin
    if (a_ge_b && a_ge_c) order = b_ge_c ? ORD_ABC : ORD_ACB;
    else if (b_ge_c)      order = a_ge_c ? ORD_BAC : ORD_BCA;
    else                  order = a_ge_b ? ORD_CAB : ORD_CBA;
  end

  // bit 0 = phase a, bit 1 = phase b, bit 2 = phase c
  always_comb begin
    case (order)
      ORD_ABC: begin hi_sel = 3'b001; lo_sel = 3'b100; end
      ORD_ACB: begin hi_sel = 3'b001; lo_sel = 3'b010; end
      ORD_BAC: begin hi_sel = 3'b010; lo_sel = 3'b100; end
      ORD_BCA: begin hi_sel = 3'b010; lo_sel = 3'b001; end
      ORD_CAB: begin hi_sel = 3'b100; lo_sel = 3'b010; end
      default: begin hi_sel = 3'b100; lo_sel = 3'b001; end
    endcase
  end

  assign ea_n = hi_sel[0] ? neg_e : (lo_sel[0] ? pos_e : '0);
  assign eb_n = hi_sel[1] ? neg_e : (lo_sel[1] ? pos_e : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o  <= 1'b0;
      ea_o <= '0;
      eb_o <= '0;
    end else begin
      v_o <= v_i;
      if (v_i) begin
        ea_o <= ea_n;
        eb_o <= eb_n;
      end
    end
  end

  assert_one_high_one_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    v_i |-> ($countones(hi_sel) == 1) && ($countones(lo_sel) == 1) && ((hi_sel & lo_sel) == 3'b000));

  assert_a_low_strict_R4: assert property (@(posedge clk) disable iff (!rst_n)
    v_i && lo_sel[0] |-> (ua < ub) && (ua < uc));

  assert_c_high_strict_R4: assert property (@(posedge clk) disable iff (!rst_n)
    v_i && hi_sel[2] |-> (uc > ua) && (uc > ub));

  assert_zero_mag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    v_i && ((idc == '0) || (k_fstov == '0)) |=> (ea_o == '0) && (eb_o == '0));
endmodule

// File: rtl/ovl_clarke.sv
module ovl_clarke
  import ovl_pkg::*;
#(
  parameter int EW = 18
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 v_i,
  input  logic signed [EW-1:0] ea_i,
  input  logic signed [EW-1:0] eb_i,
  output logic                 v_o,
  output logic signed [EW-1:0] alpha_o,
  output logic signed [EW:0]   beta_o
);
  localparam int SW  = EW + 2;
  localparam int PRW = SW + INV_SQRT3_FRAC + 2;

  function automatic logic signed [EW:0] beta_of(input logic signed [EW-1:0] a,
                                                  input logic signed [EW-1:0] b);
    logic signed [SW-1:0]  s;
    logic signed [PRW-1:0] pr;
    s  = SW'(a) + (SW'(b) <<< 1);
    pr = PRW'(s) * PRW'(INV_SQRT3_Q);
    return (EW+1)'(pr >>> INV_SQRT3_FRAC);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o     <= 1'b0;
      alpha_o <= '0;
      beta_o  <= '0;
    end else begin
      v_o <= v_i;
      if (v_i) begin
        alpha_o <= ea_i;
        beta_o  <= beta_of(ea_i, eb_i);
      end
    end
  end

  assert_beta_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
    v_i && (ea_i == '0) && (eb_i > 0) |=> (beta_o > 0));
endmodule

// File: rtl/ovl_park.sv
module ovl_park #(
  parameter int EW    = 18,
  parameter int IW    = 16,
  parameter int TW    = 16,
  parameter int TFRAC = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 v_i,
  input  logic signed [EW-1:0] alpha_i,
  input  logic signed [EW:0]   beta_i,
  input  logic signed [TW-1:0] sin_i,
  input  logic signed [TW-1:0] cos_i,
  input  logic signed [IW-1:0] idr_i,
  input  logic signed [IW-1:0] iqr_i,
  output logic                 v_o,
  output logic signed [IW-1:0] id_o,
  output logic signed [IW-1:0] iq_o
);
  localparam int BW = EW + 1;
  localparam int PW = BW + TW + 2;
  localparam logic signed [PW-1:0] SMAX = (PW'(1) <<< (IW-1)) - PW'(1);
  localparam logic signed [PW-1:0] SMIN = -SMAX - PW'(1);
  localparam logic signed [IW-1:0] OMAX = IW'(SMAX);
  localparam logic signed [IW-1:0] OMIN = IW'(SMIN);

  function automatic logic signed [PW-1:0] mac(input logic signed [BW-1:0] x1, input logic signed [TW-1:0] c1,
                                               input logic signed [BW-1:0] x2, input logic signed [TW-1:0] c2);
    return (PW'(x1) * PW'(c1) + PW'(x2) * PW'(c2)) >>> TFRAC;
  endfunction

  function automatic logic signed [IW-1:0] sat(input logic signed [PW-1:0] x);
    if (x > SMAX) return OMAX;
    if (x < SMIN) return OMIN;
    return IW'(x);
  endfunction

  logic signed [BW-1:0] a_w;
  logic signed [PW-1:0] dd, dq, id_w, iq_w;

  assign a_w  = BW'(alpha_i);
  assign dd   = mac(a_w, cos_i, beta_i, sin_i);
  assign dq   = mac(beta_i, cos_i, -a_w, sin_i);
  assign id_w = PW'(idr_i) - dd;
  assign iq_w = PW'(iqr_i) - dq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o  <= 1'b0;
      id_o <= '0;
      iq_o <= '0;
    end else begin
      v_o <= v_i;
      if (v_i) begin
        id_o <= sat(id_w);
        iq_o <= sat(iq_w);
      end
    end
  end

  assert_sat_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    v_i && (id_w > SMAX) |=> (id_o == OMAX));

  assert_sat_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    v_i && (iq_w < SMIN) |=> (iq_o == OMIN));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !v_o |-> $stable(id_o) && $stable(iq_o));
endmodule

// File: rtl/ovl_comp.sv
module ovl_comp
  import ovl_pkg::*;
#(
  parameter int VW    = 16,
  parameter int IW    = 16,
  parameter int KW    = 16,
  parameter int KFRAC = 16,
  parameter int TW    = 16,
  parameter int TFRAC = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [VW-1:0] ua,
  input  logic signed [VW-1:0] ub,
  input  logic signed [VW-1:0] uc,
  input  logic        [IW-1:0] idc,
  input  logic        [KW-1:0] k_fstov,
  input  logic signed [TW-1:0] sin_th,
  input  logic signed [TW-1:0] cos_th,
  input  logic signed [IW-1:0] id_ref,
  input  logic signed [IW-1:0] iq_ref,
  output logic                 out_valid,
  output logic signed [IW-1:0] id_cmd,
  output logic signed [IW-1:0] iq_cmd
);
  localparam int EW    = IW + KW + 2 - KFRAC;
  localparam int SIDEN = 2;

  typedef struct packed {
    logic signed [TW-1:0] s;
    logic signed [TW-1:0] c;
    logic signed [IW-1:0] idr;
    logic signed [IW-1:0] iqr;
  } side_t;

  side_t                side_q [SIDEN];
  logic                 v1, v2;
  logic signed [EW-1:0] ea1, eb1, alpha2;
  logic signed [EW:0]   beta2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SIDEN; i++) side_q[i] <= '0;
    end else begin
      side_q[0] <= {sin_th, cos_th, id_ref, iq_ref};
      for (int i = 1; i < SIDEN; i++) side_q[i] <= side_q[i-1];
    end
  end

  ovl_rank #(.VW(VW), .IW(IW), .KW(KW), .KFRAC(KFRAC)) u_rank (
    .clk(clk), .rst_n(rst_n), .v_i(in_valid), .ua(ua), .ub(ub), .uc(uc),
    .idc(idc), .k_fstov(k_fstov), .v_o(v1), .ea_o(ea1), .eb_o(eb1)
  );

  ovl_clarke #(.EW(EW)) u_clarke (
    .clk(clk), .rst_n(rst_n), .v_i(v1), .ea_i(ea1), .eb_i(eb1),
    .v_o(v2), .alpha_o(alpha2), .beta_o(beta2)
  );

  ovl_park #(.EW(EW), .IW(IW), .TW(TW), .TFRAC(TFRAC)) u_park (
    .clk(clk), .rst_n(rst_n), .v_i(v2), .alpha_i(alpha2), .beta_i(beta2),
    .sin_i(side_q[SIDEN-1].s), .cos_i(side_q[SIDEN-1].c),
    .idr_i(side_q[SIDEN-1].idr), .iqr_i(side_q[SIDEN-1].iqr),
    .v_o(out_valid), .id_o(id_cmd), .iq_o(iq_cmd)
  );

  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid, 3));
endmodule

// File: tb/ovl_comp_tb.sv
`timescale 1ns/1ps
module ovl_comp_tb;
  localparam int  QK  = 65536;   // 2^KFRAC
  localparam real ONE = 16384.0; // 2^TFRAC
  localparam real TOL = 3.0;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic signed [15:0] ua = '0, ub = '0, uc = '0, sin_th = '0, cos_th = '0, id_ref = '0, iq_ref = '0;
  logic        [15:0] idc = '0, k_fstov = '0;
  logic               out_valid;
  logic signed [15:0] id_cmd, iq_cmd;

  ovl_comp u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ua(ua), .ub(ub), .uc(uc),
    .idc(idc), .k_fstov(k_fstov), .sin_th(sin_th), .cos_th(cos_th),
    .id_ref(id_ref), .iq_ref(iq_ref), .out_valid(out_valid), .id_cmd(id_cmd), .iq_cmd(iq_cmd)
  );

  always #2.5 clk = ~clk;

  typedef struct { real id; real iq; int cyc; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;
  real last_id = 0.0, last_iq = 0.0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string msg, input real act, input real exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0f expected=%0f", msg, act, exp);
    end
  endtask

  function automatic real clip(input real v);
    if (v > 32767.0) return 32767.0;
    if (v < -32768.0) return -32768.0;
    return v;
  endfunction

  task automatic drive(input int a, input int b, input int c, input int i, input int k,
                       input int s, input int co, input int idr, input int iqr, input string tag);
    exp_t x;
    longint e, ka, kb, kc;
    real ea, eb, be, sn, cs;
    @(negedge clk);
    ua = 16'(a); ub = 16'(b); uc = 16'(c); idc = 16'(i); k_fstov = 16'(k);
    sin_th = 16'(s); cos_th = 16'(co); id_ref = 16'(idr); iq_ref = 16'(iqr);
    in_valid = 1'b1;
    e  = (2 * longint'(i) * longint'(k)) / QK;
    ka = longint'(a) * 4 + 2;  // priority a > b > c on equal voltage
    kb = longint'(b) * 4 + 1;
    kc = longint'(c) * 4;
    ea = (ka > kb && ka > kc) ? -real'(e) : ((ka < kb && ka < kc) ? real'(e) : 0.0);
    eb = (kb > ka && kb > kc) ? -real'(e) : ((kb < ka && kb < kc) ? real'(e) : 0.0);
    be = (ea + 2.0 * eb) / $sqrt(3.0);
    sn = real'(s) / ONE;
    cs = real'(co) / ONE;
    x.id  = clip(real'(idr) - (ea * cs + be * sn));
    x.iq  = clip(real'(iqr) - (-ea * sn + be * cs));
    x.cyc = cyc;
    x.tag = tag;
    q.push_back(x);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q.size() == 0) begin
        chk(1'b0, "R8/R9 strobe with no pending sample", 1.0, 0.0);
      end else begin
        exp_t x;
        real ai, aq;
        x  = q.pop_front();
        ai = real'(id_cmd);
        aq = real'(iq_cmd);
        chk((ai - x.id <= TOL) && (x.id - ai <= TOL), {x.tag, " id_cmd"}, ai, x.id);
        chk((aq - x.iq <= TOL) && (x.iq - aq <= TOL), {x.tag, " iq_cmd"}, aq, x.iq);
        chk(cyc - x.cyc == 3, {x.tag, " R8 latency"}, real'(cyc - x.cyc), 3.0);
        last_id = ai;
        last_iq = aq;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", q.size());
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0 && id_cmd == 0 && iq_cmd == 0, "R1 in reset", real'(id_cmd), 0.0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 strobe after reset", real'(out_valid), 0.0);
    chk(id_cmd == 0 && iq_cmd == 0, "R1 outputs after reset", real'(iq_cmd), 0.0);

    // R3/R6/R8: six orderings back-to-back at zero angle, E = 899
    drive( 300,    0, -300, 15000, 1966, 0, 16384, 1000, -500, "R3 ABC");
    drive( 300, -300,    0, 15000, 1966, 0, 16384, 1000, -500, "R3 ACB");
    drive(   0,  300, -300, 15000, 1966, 0, 16384, 1000, -500, "R3 BAC");
    drive(-300,  300,    0, 15000, 1966, 0, 16384, 1000, -500, "R3 BCA");
    drive(   0, -300,  300, 15000, 1966, 0, 16384, 1000, -500, "R3 CAB");
    drive(-300,    0,  300, 15000, 1966, 0, 16384, 1000, -500, "R3 CBA");
    idle(2);

    // R4: ties
    drive( 100,  100,  100, 15000, 1966, 0, 16384, 0, 0, "R4 all equal");
    drive( 200,  200,  -50, 15000, 1966, 0, 16384, 0, 0, "R4 a=b top");
    drive( 200,  -50,  200, 15000, 1966, 0, 16384, 0, 0, "R4 a=c top");
    drive( -50,  200,  200, 15000, 1966, 0, 16384, 0, 0, "R4 b=c top");
    drive(  50,  -70,  -70, 15000, 1966, 0, 16384, 0, 0, "R4 b=c bottom");
    idle(1);

    // R2: magnitude
    drive( 300,    0, -300,     0, 1966, 0, 16384, 1234, -4321, "R2 idc zero");
    drive( 300,    0, -300, 15000,    0, 0, 16384, 1234, -4321, "R2 k zero");
    drive( 300,    0, -300, 65535, 8192, 0, 16384, 0, 0, "R2 large E");
    drive(   0,  300, -300,   777, 5000, 0, 16384, 0, 0, "R2 small E");
    idle(1);

    // R5: rotation at several grid angles
    drive( 300,    0, -300, 15000, 1966,   8192,  14189, 0, 0, "R5 30deg ABC");
    drive(-300,  300,    0, 15000, 1966,   8192,  14189, 0, 0, "R5 30deg BCA");
    drive( 300,    0, -300, 15000, 1966,  16384,      0, 0, 0, "R5 90deg ABC");
    drive(   0, -300,  300, 15000, 1966,  11585, -11585, 0, 0, "R5 135deg CAB");
    drive(-300,    0,  300, 15000, 1966,  -8192, -14189, 0, 0, "R5 210deg CBA");
    drive( 300, -300,    0, 20000, 3000, -16384,      0, 0, 0, "R5 270deg ACB");

    // R6: arbitrary references
    drive( 300,    0, -300, 15000, 1966,   8192,  14189, -12000, 7000, "R6 refs");

    // R7: saturation rails
    drive( 300,    0, -300, 15000, 1966, 0, 16384,  32760,  32700, "R7 high rail");
    drive(-300,    0,  300, 15000, 1966, 0, 16384, -32760, -32700, "R7 low rail");
    drive( 300,    0, -300, 15000, 1966, 0, 16384,  31868,  32248, "R7 just below");
    idle(6);

    // R9: inputs change without in_valid; outputs must hold
    @(negedge clk);
    ua = 16'(-900); ub = 16'(900); uc = 16'(5); idc = 16'(40000); k_fstov = 16'(30000);
    id_ref = 16'(-100); iq_ref = 16'(100); sin_th = 16'(8192); cos_th = 16'(14189);
    repeat (6) @(negedge clk);
    chk(out_valid == 1'b0, "R9 no strobe while idle", real'(out_valid), 0.0);
    chk(real'(id_cmd) == last_id, "R9 id_cmd held", real'(id_cmd), last_id);
    chk(real'(iq_cmd) == last_iq, "R9 iq_cmd held", real'(iq_cmd), last_iq);

    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R8 every sample produced a strobe", real'(q.size()), 0.0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule